// File: doc/BRIEF.md
# Host Message Gateway with Framing

This block joins a host streaming channel to an on-chip packet network, and it works in both directions. From host to network, the host offers unframed 32-bit words through a request/acknowledge handshake. The gateway takes the first word of each message as the header and reads the payload length from the header's low 16 bits. It pushes every word into the network FIFO and tags the header with a start mark and the last payload word with a finish mark. A word is accepted only when the network FIFO has room. Exactly one word moves for each acknowledge.

From network to host, the gateway pops a show-ahead network FIFO whose words carry a finish flag. It passes only the 32 data bits to the host through a request/acknowledge handshake. If a message is shorter than the host's minimum transfer length (parameter `MIN_WORDS`, default 4), the gateway appends zero words until the minimum is reached. It raises an end indication together with the final word handed to the host.

The host-to-network side is a two-state machine:
- `FR_HEADER` moves to `FR_PAYLOAD` on an accepted header with a nonzero length.
- `FR_PAYLOAD` returns to `FR_HEADER` on the accepted last payload word.

The network-to-host side is also a two-state machine:
- `PD_PASS` moves to `PD_FILL` when a short message's finish word is taken.
- `PD_FILL` returns to `PD_PASS` when the last padding word is taken.

Top module: `hgw_top`

## Requirements
- R1: After reset, with no host request and an empty network FIFO, `h2n_ack`, `net_push`, `host_req` and `host_end` are all 0. The first accepted host word is treated as a header, and the padding count starts at zero.
- R2: `h2n_ack` equals `h2n_req` and not `net_full` in the same cycle. Each acknowledge pushes exactly one word (`net_push`), and `net_wdata` equals `h2n_data`.
- R3: The first accepted word of a message is its header. It is pushed with `net_mark[0]` (start) set, and its bits [15:0] give the payload length L in words.
- R4: For L > 0, the L-th accepted word after the header carries `net_mark[1]` (finish). Payload words carry no start mark. The next accepted word is a new header.
- R5: A header with L = 0 is pushed with both start and finish marks set (`net_mark` = 2'b11).
- R6: While `net_full` is 1, no word is acknowledged or pushed, and the framing position does not advance.
- R7: In pass mode, `host_req` equals not `rx_empty`, and `host_data` equals `rx_data` with the finish flag stripped. `rx_pop` is 1 exactly in cycles where `host_req` and `host_ack` are both 1.
- R8: When a message of N < `MIN_WORDS` words ends, the gateway offers `MIN_WORDS` − N zero words with `host_req` = 1. `host_end` is set with the last of them.
- R9: A message of N ≥ `MIN_WORDS` words gets no padding, and `host_end` is set with its finish word.
- R10: While padding words are being offered, `rx_pop` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| h2n_req | input | 1 | Host offers a word toward the network |
| h2n_data | input | 32 | Host word toward the network |
| h2n_ack | output | 1 | Host word accepted this cycle |
| net_full | input | 1 | Network FIFO cannot take a word |
| net_push | output | 1 | Write one word into the network FIFO |
| net_wdata | output | 32 | Word written into the network FIFO |
| net_mark | output | 2 | Bit 0 start mark, bit 1 finish mark |
| rx_empty | input | 1 | Network-to-host FIFO has no word |
| rx_data | input | 32 | Head word of the network-to-host FIFO |
| rx_finish | input | 1 | Head word is the last of its message |
| rx_pop | output | 1 | Remove the head word from the FIFO |
| host_req | output | 1 | Word offered to the host |
| host_data | output | 32 | Word offered to the host |
| host_end | output | 1 | Offered word completes the transfer |
| host_ack | input | 1 | Host takes the offered word |

## Verification
The assertions check four properties on every cycle:
- A finish-marked push always returns the framer to header position.
- The payload count is never zero inside a payload.
- A stall leaves the framing state untouched.
- Pops happen only on an acknowledged, non-empty head, never during padding, and padding words are zero.

Only the bench's scenarios can show the rest. These are that the marks fall on the right words for each header length (including zero), that the padding count matches each message's size around the `MIN_WORDS` boundary, and that no word is lost or duplicated when randomly gated requests, full flags and acknowledges interleave.

// File: rtl/hgw_pkg.sv
package hgw_pkg;
    typedef enum logic {
        FR_HEADER  = 1'b0,
        FR_PAYLOAD = 1'b1
    } fr_state_t;

    typedef enum logic {
        PD_PASS = 1'b0,
        PD_FILL = 1'b1
    } pd_state_t;

    localparam int MARK_START  = 0;
    localparam int MARK_FINISH = 1;
    localparam int MARK_W      = 2;
endpackage

// File: rtl/hgw_framer.sv
module hgw_framer
    import hgw_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int LEN_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic [DATA_W-1:0] data,
    output logic              ack,
    input  logic              full,
    output logic              push,
    output logic [DATA_W-1:0] wdata,
    output logic [MARK_W-1:0] mark
);
    localparam logic [LEN_W-1:0] LEN_ONE = LEN_W'(1);

    fr_state_t        state, state_d;
    logic [LEN_W-1:0] rem, rem_d;
    logic [LEN_W-1:0] hdr_len;

    assign hdr_len = data[LEN_W-1:0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= FR_HEADER;
            rem   <= '0;
        end else begin
            state <= state_d;
            rem   <= rem_d;
        end
    end

    always_comb begin
        ack     = req & ~full;
        push    = ack;
        wdata   = data;
        mark    = '0;
        state_d = state;
        rem_d   = rem;
        unique case (state)
            FR_HEADER: begin
                mark[MARK_START]  = 1'b1;
                mark[MARK_FINISH] = (hdr_len == '0);
                if (ack && hdr_len != '0) begin
                    state_d = FR_PAYLOAD;
                    rem_d   = hdr_len;
                end
            end
            FR_PAYLOAD: begin
                mark[MARK_FINISH] = (rem == LEN_ONE);
                if (ack) begin
                    rem_d = rem - LEN_ONE;
                    if (rem == LEN_ONE) state_d = FR_HEADER;
                end
            end
        endcase
    end

    // R4: after a finish-marked push the framer expects a header
    p_finish_to_header_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (push && mark[MARK_FINISH]) |=> (state == FR_HEADER));

    // R4: inside a payload there is always at least one word left
    p_payload_left_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == FR_PAYLOAD) |-> (rem != '0));

    // R6: a cycle without a push does not move the framing position
    p_stall_holds_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !push |=> ($stable(state) && $stable(rem)));
endmodule

// File: rtl/hgw_padder.sv
module hgw_padder
    import hgw_pkg::*;
#(
    parameter int DATA_W    = 32,
    parameter int MIN_WORDS = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_empty,
    input  logic [DATA_W-1:0] rx_data,
    input  logic              rx_finish,
    output logic              rx_pop,
    output logic              host_req,
    output logic [DATA_W-1:0] host_data,
    output logic              host_end,
    input  logic              host_ack
);
    localparam int              CNT_W = $clog2(MIN_WORDS + 1);
    localparam logic [CNT_W:0]  MIN_V = (CNT_W + 1)'(MIN_WORDS);

    pd_state_t        state, state_d;
    logic [CNT_W-1:0] cnt, cnt_d;
    logic [CNT_W:0]   cnt_inc;
    logic             xfer;

    assign cnt_inc = {1'b0, cnt} + 1'b1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= PD_PASS;
            cnt   <= '0;
        end else begin
            state <= state_d;
            cnt   <= cnt_d;
        end
    end

    always_comb begin
        host_req  = 1'b0;
        host_data = rx_data;
        host_end  = 1'b0;
        rx_pop    = 1'b0;
        xfer      = 1'b0;
        state_d   = state;
        cnt_d     = cnt;
        unique case (state)
            PD_PASS: begin
                host_req = ~rx_empty;
                xfer     = host_req & host_ack;
                rx_pop   = xfer;
                if (xfer) begin
                    if (rx_finish) begin
                        if (cnt_inc >= MIN_V) begin
                            host_end = 1'b1;
                            cnt_d    = '0;
                        end else begin
                            cnt_d   = cnt_inc[CNT_W-1:0];
                            state_d = PD_FILL;
                        end
                    end else if (cnt_inc <= MIN_V) begin
                        cnt_d = cnt_inc[CNT_W-1:0];
                    end
                end
            end
            PD_FILL: begin
                host_req  = 1'b1;
                host_data = '0;
                xfer      = host_ack;
                if (xfer) begin
                    if (cnt_inc == MIN_V) begin
                        host_end = 1'b1;
                        cnt_d    = '0;
                        state_d  = PD_PASS;
                    end else begin
                        cnt_d = cnt_inc[CNT_W-1:0];
                    end
                end
            end
        endcase
    end

    // R7: a pop only happens on an acknowledged, present head word
    p_pop_on_ack_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rx_pop |-> (host_ack && !rx_empty));

    // R10: the network FIFO is left alone while padding
    p_fill_no_pop_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state == PD_FILL) |-> !rx_pop);

    // R8: padding words are zero
    p_fill_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (host_req && state == PD_FILL) |-> (host_data == '0));

    // R8: completion restarts the word count
    p_end_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (host_end && host_ack) |=> (cnt == '0 && state == PD_PASS));
endmodule

// File: rtl/hgw_top.sv
module hgw_top
    import hgw_pkg::*;
#(
    parameter int DATA_W    = 32,
    parameter int LEN_W     = 16,
    parameter int MIN_WORDS = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              h2n_req,
    input  logic [DATA_W-1:0] h2n_data,
    output logic              h2n_ack,
    input  logic              net_full,
    output logic              net_push,
    output logic [DATA_W-1:0] net_wdata,
    output logic [MARK_W-1:0] net_mark,
    input  logic              rx_empty,
    input  logic [DATA_W-1:0] rx_data,
    input  logic              rx_finish,
    output logic              rx_pop,
    output logic              host_req,
    output logic [DATA_W-1:0] host_data,
    output logic              host_end,
    input  logic              host_ack
);
    hgw_framer #(.DATA_W(DATA_W), .LEN_W(LEN_W)) u_framer (
        .clk   (clk),
        .rst_n (rst_n),
        .req   (h2n_req),
        .data  (h2n_data),
        .ack   (h2n_ack),
        .full  (net_full),
        .push  (net_push),
        .wdata (net_wdata),
        .mark  (net_mark)
    );

    hgw_padder #(.DATA_W(DATA_W), .MIN_WORDS(MIN_WORDS)) u_padder (
        .clk       (clk),
        .rst_n     (rst_n),
        .rx_empty  (rx_empty),
        .rx_data   (rx_data),
        .rx_finish (rx_finish),
        .rx_pop    (rx_pop),
        .host_req  (host_req),
        .host_data (host_data),
        .host_end  (host_end),
        .host_ack  (host_ack)
    );
endmodule

// File: tb/tb_hgw_top.sv
`timescale 1ns/1ps
module tb_hgw_top;
    localparam int MINW = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        h2n_req = 1'b0;
    logic [31:0] h2n_data = '0;
    logic        h2n_ack;
    logic        net_full = 1'b0;
    logic        net_push;
    logic [31:0] net_wdata;
    logic [1:0]  net_mark;
    logic        rx_empty = 1'b1;
    logic [31:0] rx_data = '0;
    logic        rx_finish = 1'b0;
    logic        rx_pop;
    logic        host_req;
    logic [31:0] host_data;
    logic        host_end;
    logic        host_ack = 1'b0;

    always #10 clk = ~clk;

    hgw_top #(.MIN_WORDS(MINW)) dut (.*);

    int compared = 0;
    int mismatched = 0;
    bit finished = 0;

    logic [31:0] hq[$];
    logic [32:0] rq[$];
    logic [31:0] lf = 32'h1D2C_3B4A;

    // reference model state
    bit in_pay = 0;
    int rem = 0;
    bit pad = 0;
    int cnt = 0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s at %0t: actual %h expected %h", tag, $time, act, exp);
        end
    endtask

    function automatic logic [31:0] rnd();
        lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
        return lf;
    endfunction

    task automatic add_h2n(input int len);
        logic [31:0] r = rnd();
        hq.push_back({r[31:16], 16'(len)});
        for (int i = 0; i < len; i++) hq.push_back(rnd());
    endtask

    task automatic add_n2h(input int len);
        for (int i = 0; i < len; i++) rq.push_back({(i == len - 1), rnd()});
    endtask

    task automatic model_step();
        bit e_ack, fin, xfer, e_end;
        string t;
        // host to network
        e_ack = h2n_req && !net_full;
        if (h2n_req && net_full) begin
            chk("R6 ack", 32'(h2n_ack), 0);
            chk("R6 push", 32'(net_push), 0);
        end else begin
            chk("R2 ack", 32'(h2n_ack), 32'(e_ack));
            chk("R2 push", 32'(net_push), 32'(e_ack));
        end
        if (e_ack) begin
            chk("R2 wdata", net_wdata, h2n_data);
            if (!in_pay) begin
                fin = (h2n_data[15:0] == 0);
                t = fin ? "R5 mark" : "R3 mark";
                chk(t, 32'(net_mark), fin ? 32'd3 : 32'd1);
                if (!fin) begin in_pay = 1; rem = int'(h2n_data[15:0]); end
            end else begin
                chk("R4 mark", 32'(net_mark), (rem == 1) ? 32'd2 : 32'd0);
                rem--;
                if (rem == 0) in_pay = 0;
            end
            void'(hq.pop_front());
        end
        // network to host
        if (!pad) begin
            chk("R7 req", 32'(host_req), 32'(!rx_empty));
            if (!rx_empty) chk("R7 data", host_data, rx_data);
            xfer = !rx_empty && host_ack;
            chk("R7 pop", 32'(rx_pop), 32'(xfer));
            e_end = xfer && rx_finish && (cnt + 1 >= MINW);
            chk("R9 end", 32'(host_end), 32'(e_end));
            if (xfer) begin
                if (rx_finish) begin
                    if (cnt + 1 >= MINW) cnt = 0;
                    else begin cnt++; pad = 1; end
                end else if (cnt < MINW) cnt++;
                void'(rq.pop_front());
            end
        end else begin
            chk("R8 req", 32'(host_req), 1);
            chk("R8 data", host_data, 0);
            chk("R10 pop", 32'(rx_pop), 0);
            e_end = host_ack && (cnt + 1 == MINW);
            chk("R8 end", 32'(host_end), 32'(e_end));
            if (host_ack) begin
                cnt++;
                if (cnt == MINW) begin cnt = 0; pad = 0; end
            end
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    endtask

    initial begin
        // boundary lengths first, then a mix
        add_h2n(0); add_h2n(1); add_h2n(3); add_h2n(0); add_h2n(2);
        add_n2h(1); add_n2h(MINW - 1); add_n2h(MINW); add_n2h(MINW + 2); add_n2h(2);
        for (int i = 0; i < 150; i++) begin
            add_h2n(int'(rnd() % 7));
            add_n2h(int'(rnd() % 7) + 1);
        end
        repeat (4) @(negedge clk);
        #1;
        chk("R1 ack", 32'(h2n_ack), 0);
        chk("R1 push", 32'(net_push), 0);
        chk("R1 req", 32'(host_req), 0);
        chk("R1 end", 32'(host_end), 0);
        rst_n = 1'b1;
        for (int c = 0; c < 8000; c++) begin
            logic [31:0] r;
            @(negedge clk);
            r = rnd();
            h2n_req   = (hq.size() > 0) && (r[0] || c < 40);
            h2n_data  = (hq.size() > 0) ? hq[0] : 32'h0;
            net_full  = r[1] & r[2] & (c >= 40);
            rx_empty  = (rq.size() == 0) || (r[3] & r[4]);
            rx_data   = (rq.size() > 0) ? rq[0][31:0] : 32'h0;
            rx_finish = (rq.size() > 0) ? rq[0][32] : 1'b0;
            host_ack  = r[5] | r[6] | (c < 40);
            #1;
            model_step();
            if (hq.size() == 0 && rq.size() == 0 && !pad) break;
        end
        chk("R2 all host words pushed", 32'(hq.size()), 0);
        chk("R7 all network words delivered", 32'(rq.size()), 0);
        summary();
    end

    initial begin
        #(20 * 200000);
        mismatched++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end
endmodule